// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Link and Condition Flags

This unit is the arithmetic core of a small accumulator machine. Each operation it accepts carries an opcode, the current accumulator value, an operand word and the four current condition flags. One clock later it presents a result word with a write-enable bit, the updated flag set, and a jump decision for conditional branches. Instruction fetch, addressing and sequencing are outside this unit. The caller keeps the accumulator and the flags, and feeds them back on the next operation.

The link flag behaves unusually. Add, increment, compare, negate and set-to-minus-one toggle the link instead of loading it. The rotate instructions treat the link and the accumulator as one 17-bit ring. The branch test takes a three-bit mask that selects Z, N and L, plus a sense bit. With the sense bit at 0 the test is the OR of the selected flags. With the sense bit at 1 the test is true only when every selected flag is clear. An empty mask tests F instead.

Control is a two-state machine. IDLE means no result is presented. SHOW means the output registers hold a fresh result. IDLE moves to SHOW when `op_valid` is sampled high. SHOW stays in SHOW while `op_valid` stays high and returns to IDLE when it is low. Reset enters IDLE.

Top module: `acc_alu`

## Requirements
- R1: Flags are packed as bit 0 L, bit 1 N, bit 2 Z, bit 3 F. The jump mask is bit 0 L, bit 1 N, bit 2 Z. Opcodes are: 0 add byte, 1 add word, 2 compare byte, 3 compare word, 4 and byte, 5 and word, 6 load byte, 7 load word, 8 increment operand, 9 complement, 10 negate, 11 clear, 12 plus-one, 13 minus-one, 14 rotate right, 15 rotate left, 16 complement link, 17 clear flags, 18 jump test. Every other code writes nothing and leaves the flags unchanged.
- R2: After reset, and after any cycle with `op_valid` low, `res_valid`, `res_we` and `jump_take` are 0 in the following cycle. A result appears one cycle after `op_valid` is sampled high.
- R3: Add computes acc + operand. Byte forms sign-extend operand bits 7:0 to 16 bits. Increment computes operand + 1. Compare computes operand + (~acc) + 1. Each of these toggles L when bit 16 of the sum is 1 and otherwise keeps L.
- R4: Compare and jump test assert no write enable. Compare sets N and Z from its sum.
- R5: Load byte outputs operand bits 7:0 sign-extended. Load word outputs the operand. Neither changes L.
- R6: And word outputs acc & operand and takes N and Z from all 16 bits. And byte replaces only bits 7:0 with acc[7:0] & operand[7:0], keeps acc[15:8], and takes N from bit 7 and Z from bits 7:0. Neither changes L.
- R7: Complement outputs ~acc and toggles L. Negate outputs -acc and toggles L only when acc is nonzero.
- R8: Clear outputs 0 with N=0 and Z=1. Plus-one outputs 1 with N=0 and Z=0. Neither changes L. Minus-one outputs 0xFFFF with N=1 and Z=0 and toggles L.
- R9: Rotate right outputs {L, acc[15:1]} and sets L to acc[0]. Rotate left outputs {acc[14:0], L} and sets L to acc[15].
- R10: Unless stated otherwise, N is bit 15 of the result and Z is 1 exactly when the result is zero. F passes through unchanged except on clear-flags, which sets all four flags to 0. Complement-link toggles L only.
- R11: With a nonzero mask, the jump test is true when the sense bit is 0 and any selected flag is 1. It is true when the sense bit is 1 and every selected flag is 0. With a zero mask it tests F, or the inverse of F when the sense bit is 1. Only the jump test drives `jump_take` high, and it leaves all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 5 | Operation code (R1) |
| acc_in | input | 16 | Current accumulator |
| opnd_in | input | 16 | Operand word |
| flags_in | input | 4 | Current flags {F,Z,N,L} |
| cond_mask | input | 3 | Jump mask {Z,N,L} |
| cond_tf | input | 1 | Jump sense bit |
| res_valid | output | 1 | Result registers hold a fresh result |
| res_data | output | 16 | Result word |
| res_we | output | 1 | Result is to be written |
| flags_out | output | 4 | Updated flags |
| jump_take | output | 1 | Jump decision |

## Verification
The hardest cases to reach are the ones that depend on a carry out of bit 15 combined with the link's previous value. Examples are a compare of equal values and an add that wraps exactly to zero. Uniform random operands seldom produce these. The stimulus therefore draws operands that are often tied to the accumulator (equal, complemented or negated) or set to the extremes 0, 0x7FFF, 0x8000 and 0xFFFF. Directed cases also cover a negate of zero, rotates that carry the link around the ring, and an empty jump mask.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
    typedef enum logic [4:0] {
        OP_ADDB = 5'd0,  OP_ADDW = 5'd1,  OP_CMPB = 5'd2,  OP_CMPW = 5'd3,
        OP_ANDB = 5'd4,  OP_ANDW = 5'd5,  OP_LDB  = 5'd6,  OP_LDW  = 5'd7,
        OP_INC  = 5'd8,  OP_CMA  = 5'd9,  OP_NEG  = 5'd10, OP_CLA  = 5'd11,
        OP_PLS1 = 5'd12, OP_MIN1 = 5'd13, OP_ROR  = 5'd14, OP_ROL  = 5'd15,
        OP_CML  = 5'd16, OP_CLRF = 5'd17, OP_JTST = 5'd18
    } op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } st_e;

    localparam int FL_L = 0;
    localparam int FL_N = 1;
    localparam int FL_Z = 2;
    localparam int FL_F = 3;
    localparam int FLAG_W = 4;
    localparam int MASK_W = 3;
endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] opnd,
    output logic [DATA_W-1:0] sum,
    output logic              carry
);
    localparam int BYTE_W = DATA_W / 2;

    logic [DATA_W-1:0] ext_b;
    logic [DATA_W-1:0] a_in;
    logic [DATA_W-1:0] b_in;
    logic              c_in;
    logic [DATA_W:0]   full;

    assign ext_b = {{(DATA_W-BYTE_W){opnd[BYTE_W-1]}}, opnd[BYTE_W-1:0]};

    always_comb begin
        a_in = acc;
        b_in = opnd;
        c_in = 1'b0;
        unique case (op)
            OP_ADDB: b_in = ext_b;
            OP_CMPB: begin a_in = ~acc; b_in = ext_b; c_in = 1'b1; end
            OP_CMPW: begin a_in = ~acc; c_in = 1'b1; end
            OP_INC:  begin a_in = opnd; b_in = '0; c_in = 1'b1; end
            default: ;
        endcase
    end

    assign full  = {1'b0, a_in} + {1'b0, b_in} + {{DATA_W{1'b0}}, c_in};
    assign sum   = full[DATA_W-1:0];
    assign carry = full[DATA_W];
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] opnd,
    input  logic              link,
    output logic [DATA_W-1:0] res,
    output logic              link_out
);
    localparam int BYTE_W = DATA_W / 2;

    always_comb begin
        res      = '0;
        link_out = link;
        unique case (op)
            OP_ANDB: res = {acc[DATA_W-1:BYTE_W], acc[BYTE_W-1:0] & opnd[BYTE_W-1:0]};
            OP_ANDW: res = acc & opnd;
            OP_LDB:  res = {{(DATA_W-BYTE_W){opnd[BYTE_W-1]}}, opnd[BYTE_W-1:0]};
            OP_LDW:  res = opnd;
            OP_CMA:  begin res = ~acc; link_out = ~link; end
            OP_NEG:  begin res = ~acc + 1'b1; link_out = link ^ (|acc); end
            OP_CLA:  res = '0;
            OP_PLS1: res = {{(DATA_W-1){1'b0}}, 1'b1};
            OP_MIN1: begin res = '1; link_out = ~link; end
            OP_ROR:  begin res = {link, acc[DATA_W-1:1]}; link_out = acc[0]; end
            OP_ROL:  begin res = {acc[DATA_W-2:0], link}; link_out = acc[DATA_W-1]; end
            OP_CML:  link_out = ~link;
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_alu_cond.sv
module acc_alu_cond
    import acc_alu_pkg::*;
(
    input  logic [FLAG_W-1:0] flags,
    input  logic [MASK_W-1:0] mask,
    input  logic              tf,
    output logic              take
);
    logic [MASK_W-1:0] picked;

    assign picked = mask & {flags[FL_Z], flags[FL_N], flags[FL_L]};

    always_comb begin
        if (mask == '0) take = flags[FL_F] ^ tf;
        else if (tf)    take = (picked == '0);
        else            take = (picked != '0);
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [4:0]        op_code,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd_in,
    input  logic [3:0]        flags_in,
    input  logic [2:0]        cond_mask,
    input  logic              cond_tf,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic              res_we,
    output logic [3:0]        flags_out,
    output logic              jump_take
);
    localparam int BYTE_W = DATA_W / 2;

    op_e               op;
    st_e               state, state_nx;
    logic [DATA_W-1:0] add_sum, log_res, res_c;
    logic              add_c, log_l, take_c, we_c;
    logic [FLAG_W-1:0] fl_c;
    op_e               op_q;
    logic [FLAG_W-1:0] fin_q;

    assign op = op_e'(op_code);

    acc_alu_adder #(.DATA_W(DATA_W)) u_add (
        .op(op), .acc(acc_in), .opnd(opnd_in), .sum(add_sum), .carry(add_c)
    );
    acc_alu_logic #(.DATA_W(DATA_W)) u_log (
        .op(op), .acc(acc_in), .opnd(opnd_in), .link(flags_in[FL_L]),
        .res(log_res), .link_out(log_l)
    );
    acc_alu_cond u_cond (
        .flags(flags_in), .mask(cond_mask), .tf(cond_tf), .take(take_c)
    );

    always_comb begin
        res_c  = log_res;
        fl_c   = flags_in;
        we_c   = 1'b0;
        unique case (op)
            OP_ADDB, OP_ADDW, OP_INC, OP_CMPB, OP_CMPW: begin
                res_c       = add_sum;
                fl_c[FL_L]  = flags_in[FL_L] ^ add_c;
                fl_c[FL_N]  = add_sum[DATA_W-1];
                fl_c[FL_Z]  = (add_sum == '0);
                we_c        = (op != OP_CMPB) && (op != OP_CMPW);
            end
            OP_ANDB: begin
                fl_c[FL_N]  = log_res[BYTE_W-1];
                fl_c[FL_Z]  = (log_res[BYTE_W-1:0] == '0);
                we_c        = 1'b1;
            end
            OP_ANDW, OP_LDB, OP_LDW, OP_CMA, OP_NEG, OP_CLA,
            OP_PLS1, OP_MIN1, OP_ROR, OP_ROL: begin
                fl_c[FL_L]  = log_l;
                fl_c[FL_N]  = log_res[DATA_W-1];
                fl_c[FL_Z]  = (log_res == '0);
                we_c        = 1'b1;
            end
            OP_CML:  fl_c[FL_L] = log_l;
            OP_CLRF: fl_c = '0;
            default: ;
        endcase
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (op_valid)  state_nx = ST_SHOW;
            ST_SHOW: if (!op_valid) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_data  <= '0;
            res_we    <= 1'b0;
            flags_out <= '0;
            jump_take <= 1'b0;
            op_q      <= OP_CLA;
            fin_q     <= '0;
        end else if (op_valid) begin
            res_data  <= res_c;
            res_we    <= we_c;
            flags_out <= fl_c;
            jump_take <= (op == OP_JTST) && take_c;
            op_q      <= op;
            fin_q     <= flags_in;
        end else begin
            res_we    <= 1'b0;
            jump_take <= 1'b0;
        end
    end

    assign res_valid = (state == ST_SHOW);
endmodule

// File: rtl/acc_alu_checker.sv
module acc_alu_checker
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic              res_valid,
    input logic              res_we,
    input logic              jump_take,
    input logic [DATA_W-1:0] res_data,
    input logic [3:0]        flags_out,
    input op_e               op_q,
    input logic [3:0]        fin_q
);
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_valid && !res_we && !jump_take));

    p_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (op_q == OP_CMPB || op_q == OP_CMPW || op_q == OP_JTST)) |-> !res_we);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && op_q == OP_CLA) |-> (res_data == '0 && flags_out[FL_Z] && !flags_out[FL_N]));

    p_f_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && op_q != OP_CLRF) |-> (flags_out[FL_F] == fin_q[FL_F]));

    p_jtst_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && op_q == OP_JTST) |-> (flags_out == fin_q));

    p_jump_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && op_q != OP_JTST) |-> !jump_take);

    p_zero_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (op_q == OP_ADDW || op_q == OP_LDW || op_q == OP_NEG || op_q == OP_ROR))
        |-> (flags_out[FL_Z] == (res_data == '0)));
endmodule

bind acc_alu acc_alu_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .res_valid(res_valid),
    .res_we(res_we), .jump_take(jump_take), .res_data(res_data),
    .flags_out(flags_out), .op_q(op_q), .fin_q(fin_q)
);

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [4:0]  op_code = '0;
    logic [15:0] acc_in = '0, opnd_in = '0;
    logic [3:0]  flags_in = '0;
    logic [2:0]  cond_mask = '0;
    logic        cond_tf = 1'b0;
    logic        res_valid, res_we, jump_take;
    logic [15:0] res_data;
    logic [3:0]  flags_out;
    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    acc_alu u_acc_alu (.*);

    // returns {jump, we, flags[3:0], res[15:0]}
    function automatic logic [21:0] model(input logic [4:0] op, input logic [15:0] a,
        input logic [15:0] b, input logic [3:0] f, input logic [2:0] m, input logic tf);
        logic [15:0] r; logic [16:0] s; logic [3:0] nf; logic we, j, cz;
        logic [15:0] bx;
        logic [2:0] sel;
        bx = {{8{b[7]}}, b[7:0]};
        r = 16'h0; nf = f; we = 1'b1; j = 1'b0; cz = 1'b1;
        case (op)
            5'd0: s = a + bx;
            5'd1: s = a + b;
            5'd2: s = {1'b0, ~a} + bx + 17'd1;
            5'd3: s = {1'b0, ~a} + b + 17'd1;
            5'd8: s = b + 17'd1;
            default: s = '0;
        endcase
        case (op)
            5'd0, 5'd1, 5'd2, 5'd3, 5'd8: begin r = s[15:0]; nf[0] = f[0] ^ s[16];
                                                 we = !(op == 5'd2 || op == 5'd3); end
            5'd4: begin r = {a[15:8], a[7:0] & b[7:0]}; cz = 1'b0;
                        nf[1] = r[7]; nf[2] = (r[7:0] == 0); end
            5'd5: r = a & b;
            5'd6: r = bx;
            5'd7: r = b;
            5'd9: begin r = ~a; nf[0] = ~f[0]; end
            5'd10: begin r = -a; nf[0] = f[0] ^ (a != 0); end
            5'd11: r = 16'h0;
            5'd12: r = 16'h1;
            5'd13: begin r = 16'hFFFF; nf[0] = ~f[0]; end
            5'd14: begin r = {f[0], a[15:1]}; nf[0] = a[0]; end
            5'd15: begin r = {a[14:0], f[0]}; nf[0] = a[15]; end
            5'd16: begin we = 0; cz = 0; nf[0] = ~f[0]; end
            5'd17: begin we = 0; cz = 0; nf = 4'h0; end
            5'd18: begin we = 0; cz = 0;
                   sel = m & {f[2], f[1], f[0]};
                   if (m == 0) j = f[3] ^ tf;
                   else j = tf ? (sel == 0) : (sel != 0); end
            default: begin we = 0; cz = 0; end
        endcase
        if (cz) begin nf[1] = r[15]; nf[2] = (r == 0); end
        if (!we && op != 5'd2 && op != 5'd3 && op <= 5'd18 && op >= 5'd16) r = 16'h0;
        return {j, we, nf, r};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string tag(input logic [4:0] op);
        case (op)
            5'd0, 5'd1, 5'd8: return "R3";
            5'd2, 5'd3: return "R4";
            5'd6, 5'd7: return "R5";
            5'd4, 5'd5: return "R6";
            5'd9, 5'd10: return "R7";
            5'd11, 5'd12, 5'd13: return "R8";
            5'd14, 5'd15: return "R9";
            5'd18: return "R11";
            default: return "R10";
        endcase
    endfunction

    task automatic run(input logic [4:0] op, input logic [15:0] a, input logic [15:0] b,
                       input logic [3:0] f, input logic [2:0] m, input logic tf);
        logic [21:0] e;
        e = model(op, a, b, f, m, tf);
        @(negedge clk);
        op_valid = 1; op_code = op; acc_in = a; opnd_in = b;
        flags_in = f; cond_mask = m; cond_tf = tf;
        @(negedge clk);
        op_valid = 0;
        check("R2", {31'd0, res_valid}, 32'd1);
        // result data only meaningful when written (R1)
        if (e[20]) check(tag(op), {16'd0, res_data}, {16'd0, e[15:0]});
        check(tag(op), {26'd0, jump_take, res_we, flags_out}, {26'd0, e[21:16]});
    endtask

    initial begin : wd
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] a, b;
        logic [4:0] op;
        int unsigned seed;
        seed = 32'h5EED;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        check("R2", {29'd0, res_valid, res_we, jump_take}, 32'd0);
        rst_n = 1;
        // directed corners
        run(5'd3, 16'h1234, 16'h1234, 4'b0000, 0, 0);   // R4 equal compare: carry toggles L
        run(5'd1, 16'h8000, 16'h8000, 4'b0001, 0, 0);   // R3 wrap to zero
        run(5'd10, 16'h0000, 16'h0, 4'b0001, 0, 0);     // R7 negate zero keeps L
        run(5'd10, 16'h8000, 16'h0, 4'b0000, 0, 0);     // R7
        run(5'd14, 16'h0001, 16'h0, 4'b0000, 0, 0);     // R9 ring to zero
        run(5'd15, 16'h8000, 16'h0, 4'b0001, 0, 0);     // R9
        run(5'd4, 16'hAB0F, 16'h00F0, 4'b1000, 0, 0);   // R6 byte zero, high kept
        run(5'd6, 16'h0, 16'h0080, 4'b0001, 0, 0);      // R5 sign extend
        run(5'd13, 16'h0, 16'h0, 4'b1001, 0, 0);        // R8
        run(5'd17, 16'h0, 16'h0, 4'b1111, 0, 0);        // R10 clear flags
        run(5'd18, 16'h0, 16'h0, 4'b1000, 3'b000, 0);   // R11 empty mask tests F
        run(5'd18, 16'h0, 16'h0, 4'b0100, 3'b101, 1);   // R11 AND of false
        run(5'd18, 16'h0, 16'h0, 4'b0010, 3'b101, 1);   // R11
        run(5'd25, 16'h5555, 16'h1, 4'b1010, 0, 0);     // R1 undefined code
        @(negedge clk);
        check("R2", {29'd0, res_valid, res_we, jump_take}, 32'd0);
        for (int i = 0; i < 600; i++) begin
            op = 5'($urandom_range(0, 19));
            a = 16'($urandom);
            case ($urandom_range(0, 5))
                0: b = a;
                1: b = ~a;
                2: b = -a;
                3: b = ($urandom_range(0, 1) != 0) ? 16'h7FFF : 16'h8000;
                4: b = ($urandom_range(0, 1) != 0) ? 16'h0000 : 16'hFFFF;
                default: b = 16'($urandom);
            endcase
            run(op, a, b, 4'($urandom), 3'($urandom), 1'($urandom));
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule